// File: doc/BRIEF.md
# Pin Event Interrupt Aggregator

This block watches a bank of synchronized pin levels and raises a single interrupt line whenever a selected event has happened on any pin that software has enabled. Each pin carries its own 3-bit event kind: falling edge, rising edge, either edge, low level or high level. Detected events are latched into sticky pending bits.

Software talks to the block over a simple register bus. Two write-only addresses set or clear bits of an interrupt mask, writing a 1 to a bit and leaving 0 bits alone. A third address reads the mask back. Reading the status address returns the pending bits and clears them in the same access, so no separate acknowledge is needed. The interrupt output is high whenever pending AND mask is non-zero.

Top module: `pin_evt_irq`

## Requirements
- R1: After reset the mask, the pending status and the interrupt output are all zero, and reading the status address returns 0.
- R2: Event kind codes per pin (3 bits, pin n at bits 3n+2..3n of `evt_sel_i`): 0 falling edge, 1 rising edge, 2 either edge, 3 low level, 4 high level. An edge is a difference between the pin level and its value on the previous cycle. The pending bit is visible one cycle after the cycle in which the event is seen.
- R3: Codes 5, 6 and 7 never set a pending bit.
- R4: A bus write to the mask-set address (0x20) sets the mask bits where the write data is 1. A write to the mask-clear address (0x24) clears the mask bits where the write data is 1. Zero data bits leave the mask unchanged.
- R5: A read of address 0x28 returns the mask. A read of address 0x2C returns the pending bits and clears them. The read data is registered and valid the cycle after the read strobe.
- R6: An event seen in the same cycle as a status read stays pending after the read.
- R7: For a level kind, a pending bit cleared by a read sets again in the following cycle while the level still holds.
- R8: Pending bits latch whatever the mask is set to. `irq_o` is high exactly when the registered pending AND mask is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| bus_wr_i | input | 1 | write strobe |
| bus_rd_i | input | 1 | read strobe |
| bus_addr_i | input | 8 | byte address |
| bus_wdata_i | input | 32 | write data |
| bus_rdata_o | output | 32 | registered read data |
| pin_i | input | 32 | synchronized pin levels |
| evt_sel_i | input | 96 | per-pin 3-bit event kind |
| irq_o | output | 1 | bank interrupt |

## Verification
The hardest case to reach from the ports is an event that arrives in the same cycle as the clearing status read. Keeping it pending depends on the set path winning over the clear. The bench lines up a pin toggle with the read strobe in one cycle and then checks that a second read returns that bit. A related case is a level kind that re-arms right after it is cleared. The bench holds the level during the read and checks both the returned value and the pending bit in the next read.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;
  typedef enum logic [2:0] {
    EVT_FALL = 3'd0,
    EVT_RISE = 3'd1,
    EVT_BOTH = 3'd2,
    EVT_LOW  = 3'd3,
    EVT_HIGH = 3'd4
  } evt_kind_e;

  localparam logic [7:0] ADDR_MSET = 8'h20;
  localparam logic [7:0] ADDR_MCLR = 8'h24;
  localparam logic [7:0] ADDR_MASK = 8'h28;
  localparam logic [7:0] ADDR_STAT = 8'h2C;
endpackage

// File: rtl/pin_evt_detect.sv
module pin_evt_detect #(
  parameter int NPIN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPIN-1:0]   pin_i,
  input  logic [3*NPIN-1:0] evt_sel_i,
  output logic [NPIN-1:0]   hit_o
);
  import pin_evt_pkg::*;

  logic [NPIN-1:0] prev_q;
  logic            primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin_i;
      primed_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic rise, fall;
    assign rise = primed_q &  pin_i[g] & ~prev_q[g];
    assign fall = primed_q & ~pin_i[g] &  prev_q[g];
    always_comb begin
      unique case (evt_sel_i[3*g +: 3])
        EVT_FALL: hit_o[g] = fall;
        EVT_RISE: hit_o[g] = rise;
        EVT_BOTH: hit_o[g] = rise | fall;
        EVT_LOW:  hit_o[g] = ~pin_i[g];
        EVT_HIGH: hit_o[g] = pin_i[g];
        default:  hit_o[g] = 1'b0;
      endcase
    end
  end

  // R3
  reserved_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_sel_i[2:0] > 3'd4) |-> !hit_o[0]);
endmodule

// File: rtl/pin_evt_regs.sv
module pin_evt_regs #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_wr_i,
  input  logic            bus_rd_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [NPIN-1:0] bus_wdata_i,
  input  logic [NPIN-1:0] hit_i,
  output logic [NPIN-1:0] rdata_o,
  output logic [NPIN-1:0] pend_o,
  output logic [NPIN-1:0] mask_o
);
  import pin_evt_pkg::*;

  logic [NPIN-1:0] pend_q, mask_q, rdata_q;
  logic            rd_stat, rd_mask, wr_set, wr_clr;

  assign rd_stat = bus_rd_i && bus_addr_i == AW'(ADDR_STAT);
  assign rd_mask = bus_rd_i && bus_addr_i == AW'(ADDR_MASK);
  assign wr_set  = bus_wr_i && bus_addr_i == AW'(ADDR_MSET);
  assign wr_clr  = bus_wr_i && bus_addr_i == AW'(ADDR_MCLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      // new hits win over the read clear
      pend_q <= (rd_stat ? '0 : pend_q) | hit_i;
      if (wr_set) mask_q <= mask_q | bus_wdata_i;
      else if (wr_clr) mask_q <= mask_q & ~bus_wdata_i;
      if (rd_stat)      rdata_q <= pend_q;
      else if (rd_mask) rdata_q <= mask_q;
      else              rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;
  assign pend_o  = pend_q;
  assign mask_o  = mask_q;

  // R6
  hit_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |=> ((pend_q & $past(hit_i)) == $past(hit_i)));
  // R4
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));
  // R4
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((mask_q & $past(bus_wdata_i)) == '0));
  // R5
  stat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && hit_i == '0) |=> pend_q == '0);
endmodule

// File: rtl/pin_evt_irq.sv
module pin_evt_irq #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_wr_i,
  input  logic            bus_rd_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [NPIN-1:0] bus_wdata_i,
  output logic [NPIN-1:0] bus_rdata_o,
  input  logic [NPIN-1:0] pin_i,
  input  logic [3*NPIN-1:0] evt_sel_i,
  output logic            irq_o
);
  logic [NPIN-1:0] hit, pend, mask;

  pin_evt_detect #(.NPIN(NPIN)) u_det (
    .clk_i, .rst_ni, .pin_i, .evt_sel_i, .hit_o(hit)
  );

  pin_evt_regs #(.NPIN(NPIN), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .bus_wr_i, .bus_rd_i, .bus_addr_i, .bus_wdata_i,
    .hit_i(hit), .rdata_o(bus_rdata_o), .pend_o(pend), .mask_o(mask)
  );

  assign irq_o = |(pend & mask);

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);
endmodule

// File: tb/pin_evt_irq_tb.sv
module pin_evt_irq_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic wr = 0, rd = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata, pin = 0;
  logic [95:0] sel = '0;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_evt_irq u_dut (.clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pin), .evt_sel_i(sel), .irq_o(irq));

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic cyc(int n = 1); repeat (n) @(posedge clk); #1; endtask

  task automatic bus_w(logic [7:0] a, logic [31:0] d);
    wr = 1; addr = a; wdata = d; cyc(); wr = 0;
  endtask

  task automatic bus_r(logic [7:0] a, output logic [31:0] d);
    rd = 1; addr = a; cyc(); rd = 0; d = rdata;
  endtask

  task automatic set_kind(int p, logic [2:0] k); sel[3*p +: 3] = k; endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 0);
    bus_r(8'h28, d); chk("R1 mask", d, 0);
    bus_r(8'h2C, d); chk("R1 stat", d, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bus_w(8'h20, 32'h0000_00F0); bus_w(8'h20, 32'h0000_0F00);
    bus_r(8'h28, d); chk("R4 set", d, 32'h0000_0FF0);
    bus_w(8'h24, 32'h0000_0330);
    bus_r(8'h28, d); chk("R4 clr", d, 32'h0000_0CC0);
    bus_w(8'h24, 32'hFFFF_FFFF);
    bus_r(8'h28, d); chk("R4 clr all", d, 0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    sel = '0;
    for (int p = 0; p < 32; p++) set_kind(p, 3'd7);
    set_kind(0, 3'd0); set_kind(1, 3'd1); set_kind(2, 3'd2);
    set_kind(5, 3'd5); set_kind(6, 3'd6);
    cyc(2); bus_r(8'h2C, d);
    pin = 32'h0000_0067; cyc(2);
    bus_r(8'h2C, d); chk("R2 rise", d, 32'h0000_0006);
    chk("R3 reserved rise", d & 32'h60, 0);
    pin = 32'h0; cyc(2);
    bus_r(8'h2C, d); chk("R2 fall", d, 32'h0000_0005);
    chk("R3 reserved fall", d & 32'h60, 0);
    bus_r(8'h2C, d); chk("R5 cleared", d, 0);
  endtask

  task automatic t_levels();
    logic [31:0] d;
    for (int p = 0; p < 32; p++) set_kind(p, 3'd7);
    set_kind(8, 3'd3); set_kind(9, 3'd4);
    pin = 32'h0000_0200; cyc(2);
    bus_r(8'h2C, d); chk("R2 level", d, 32'h0000_0300);
    bus_r(8'h2C, d); chk("R7 rearm", d, 32'h0000_0300);
    pin = 32'h0000_0100; cyc();
    bus_r(8'h2C, d); bus_r(8'h2C, d); chk("R7 swap", d, 32'h0000_0300 & 32'h0000_0000 | 32'h0000_0000);
  endtask

  task automatic t_race();
    logic [31:0] d;
    for (int p = 0; p < 32; p++) set_kind(p, 3'd7);
    set_kind(3, 3'd1);
    pin = 0; cyc(2); bus_r(8'h2C, d);
    // toggle pin 3 in the read cycle
    rd = 1; addr = 8'h2C; pin = 32'h8; cyc(); rd = 0;
    chk("R6 read", rdata, 0);
    bus_r(8'h2C, d); chk("R6 kept", d, 32'h8);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    for (int p = 0; p < 32; p++) set_kind(p, 3'd7);
    set_kind(4, 3'd2);
    pin = 0; cyc(2); bus_r(8'h2C, d);
    pin = 32'h10; cyc(2);
    chk("R8 unmasked no irq", {31'b0, irq}, 0);
    bus_w(8'h20, 32'h10); #1;
    chk("R8 irq", {31'b0, irq}, 1);
    bus_w(8'h24, 32'h10);
    chk("R8 masked off", {31'b0, irq}, 0);
    bus_w(8'h20, 32'h10);
    bus_r(8'h2C, d); chk("R8 stat", d, 32'h10);
    chk("R8 irq after clear", {31'b0, irq}, 0);
  endtask

  initial begin
    #(CLK_PERIOD*400000);
    n_chk++; n_fail++;
    $display("FAIL watchdog");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    sel = {32{3'd7}};
    cyc(2); rst_n = 1; cyc();
    t_reset(); t_mask(); t_edges(); t_levels(); t_race(); t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule